// File: doc/BRIEF.md
# Outstanding Miss Table

A small table that records the cache line misses a lockup-free cache has sent to the next level and not yet seen filled. Each occupied slot holds a line address, a request command, the way the fill will land in, and a flag marking a miss already satisfied by the second level. The cache presents a miss on the allocate port and is told in the same cycle whether the miss got a new slot, joined an existing slot for the same line, collided with another miss, or found the table full. An allocation that gets a new slot is written into the table at the next clock edge.

Slots are released in two ways. The fill logic frees a slot by index, for example when the next level answers retry or bus error. Coherence logic removes slots by address. A classify query tells the pipeline what kind of outstanding miss, if any, covers an address. A sync request is held off while any slot is occupied and is passed on once the table is empty.

Top module: `mht_table`

## Requirements
- R1: After reset no slot is occupied, `busy_count` is 0, a sync request is answered with `sync_issue`=1, and every query reports `query_err`.
- R2: Addresses are compared by line only. The low `LINE_OFF` bits (default 5, for 32-byte lines) of the allocate, remove and query addresses are ignored.
- R3: An allocation that neither matches a line nor collides, made while a slot is free, answers `alloc_rsp`=0 (new slot) with `alloc_idx` equal to the lowest-numbered free slot. It raises `busy_count` by one at the next edge.
- R4: An allocation whose line matches an occupied slot answers 1 (merge) with that slot's index when the held command is exclusive or the new command is shared. No slot is added. Command codes are 0 shared fetch, 1 exclusive fetch, 2 upgrade, 3 conditional-store upgrade; codes 1 to 3 count as exclusive.
- R5: An allocation answers 2 (conflict), and changes nothing, in two cases: the line matches a slot that holds a shared fetch while exclusive ownership is requested; or a different line occupies a slot with the same set index (line-address bits [SET_W-1:0], default 7 bits) and the same way.
- R6: With every slot occupied and no match or collision, an allocation answers 3 (full) and the table is unchanged.
- R7: A free request clears the slot at `free_idx`. A free request aimed at an unoccupied slot has no effect on the count.
- R8: A remove request clears every occupied slot whose line equals the line of `remove_addr`. An address with no matching slot changes nothing.
- R9: `busy_count` equals the number of occupied slots. An allocation and a free in the same cycle leave it unchanged.
- R10: While `sync_req` is high, `sync_stall` is 1 if any slot is occupied and `sync_issue` is 1 if none is. The two are never 1 together.
- R11: A query whose line matches an occupied slot reports `query_kind` 0 (first-level) if the slot's second-level-hit flag is set. Otherwise it reports 2 (second level, upgrade) for commands 2 and 3, and 1 (second level) for any other command.
- R12: A query with no matching slot raises `query_err` and reports `query_kind`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | 1 | Allocate a miss this cycle |
| alloc_addr | input | ADDR_W | Physical address of the miss |
| alloc_cmd | input | 2 | Request command code |
| alloc_way | input | WAY_W | Target way of the fill |
| alloc_l2hit | input | 1 | Miss was already satisfied at the second level |
| alloc_rsp | output | 2 | 0 new slot, 1 merge, 2 conflict, 3 full |
| alloc_idx | output | IDX_W | Slot index for a new slot or a merge, else 0 |
| free_req | input | 1 | Free one slot by index |
| free_idx | input | IDX_W | Slot to free |
| remove_req | input | 1 | Remove slots by address |
| remove_addr | input | ADDR_W | Address whose line is removed |
| query_req | input | 1 | Classify request |
| query_addr | input | ADDR_W | Address to classify |
| query_kind | output | 2 | 0 first-level, 1 second level, 2 second level upgrade, 3 none |
| query_err | output | 1 | Query found no matching slot |
| sync_req | input | 1 | Barrier request |
| sync_stall | output | 1 | Barrier must wait |
| sync_issue | output | 1 | Barrier may be forwarded to memory |
| busy_count | output | CNT_W | Number of occupied slots |

## Verification
A corrupted valid bit or a wrong stored line would show on the next allocate or query to that line as a wrong outcome: a fresh slot where a merge belongs, or an error where a classification belongs. It would also show as soon as `busy_count` stops equalling the number of occupied slots. A count that drifts would hold a sync stalled forever, or release it early. The bench therefore reads every answer in the cycle it is given and checks the count one edge after each change. It drains the table at the end so that the sync answer shows any residue left in the table.

// File: rtl/mht_pkg.sv
package mht_pkg;

  typedef enum logic [1:0] {
    CMD_GETS  = 2'd0,
    CMD_GETX  = 2'd1,
    CMD_UPG   = 2'd2,
    CMD_SCUPG = 2'd3
  } mht_cmd_e;

  typedef enum logic [1:0] {
    RSP_OK       = 2'd0,
    RSP_MERGE    = 2'd1,
    RSP_CONFLICT = 2'd2,
    RSP_FULL     = 2'd3
  } mht_rsp_e;

  typedef enum logic [1:0] {
    CLS_L1     = 2'd0,
    CLS_L2     = 2'd1,
    CLS_L2_UPG = 2'd2,
    CLS_NONE   = 2'd3
  } mht_cls_e;

  // any command other than a shared fetch asks for ownership
  function automatic logic cmd_excl(mht_cmd_e c);
    return c != CMD_GETS;
  endfunction

  // a waiting miss absorbs a new one if it already asks for as much
  function automatic logic merge_ok(mht_cmd_e held, mht_cmd_e want);
    return cmd_excl(held) || !cmd_excl(want);
  endfunction

  function automatic mht_cls_e classify(logic l2hit, mht_cmd_e c);
    if (l2hit) return CLS_L1;
    if (c == CMD_UPG || c == CMD_SCUPG) return CLS_L2_UPG;
    return CLS_L2;
  endfunction

endpackage

// File: rtl/mht_line_cmp.sv
module mht_line_cmp #(
  parameter int N  = 8,
  parameter int LW = 27
) (
  input  logic [N-1:0]         vld,
  input  logic [N-1:0][LW-1:0] lines,
  input  logic [LW-1:0]        probe,
  output logic [N-1:0]         hit
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hit[g] = vld[g] && (lines[g] == probe);
  end
endmodule

// File: rtl/mht_first.sv
module mht_first #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mht_table.sv
module mht_table
  import mht_pkg::*;
#(
  parameter int N_ENT    = 8,
  parameter int ADDR_W   = 32,
  parameter int LINE_OFF = 5,
  parameter int SET_W    = 7,
  parameter int WAY_W    = 2,
  localparam int IDX_W   = $clog2(N_ENT),
  localparam int CNT_W   = $clog2(N_ENT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_req,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic [1:0]        alloc_cmd,
  input  logic [WAY_W-1:0]  alloc_way,
  input  logic              alloc_l2hit,
  output logic [1:0]        alloc_rsp,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic              free_req,
  input  logic [IDX_W-1:0]  free_idx,
  input  logic              remove_req,
  input  logic [ADDR_W-1:0] remove_addr,
  input  logic              query_req,
  input  logic [ADDR_W-1:0] query_addr,
  output logic [1:0]        query_kind,
  output logic              query_err,
  input  logic              sync_req,
  output logic              sync_stall,
  output logic              sync_issue,
  output logic [CNT_W-1:0]  busy_count
);
  localparam int LINE_W = ADDR_W - LINE_OFF;

  function automatic logic [CNT_W-1:0] next_count(logic [CNT_W-1:0] cur,
                                                  logic inc,
                                                  logic [CNT_W-1:0] dec);
    return cur + CNT_W'(inc) - dec;
  endfunction

  // table state
  logic [N_ENT-1:0]              vld;
  logic [N_ENT-1:0][LINE_W-1:0]  e_line;
  logic [N_ENT-1:0][1:0]         e_cmd;
  logic [N_ENT-1:0][WAY_W-1:0]   e_way;
  logic [N_ENT-1:0]              e_l2;
  logic [CNT_W-1:0]              count;

  // line numbers of the three probes
  logic [LINE_W-1:0] a_line, r_line, q_line;
  assign a_line = alloc_addr[ADDR_W-1:LINE_OFF];
  assign r_line = remove_addr[ADDR_W-1:LINE_OFF];
  assign q_line = query_addr[ADDR_W-1:LINE_OFF];

  wire unused_offsets = ^{alloc_addr[LINE_OFF-1:0], remove_addr[LINE_OFF-1:0],
                          query_addr[LINE_OFF-1:0]};

  // named internal events (observed by the checker)
  logic [N_ENT-1:0] am_hit, rm_hit, qm_hit, sw_hit;
  logic             am_any, fp_any, qp_any;
  logic [IDX_W-1:0] am_idx, fp_idx, qp_idx;
  logic             alloc_ok;
  logic [N_ENT-1:0] clr, drop, set_oh;
  logic [CNT_W-1:0] dec;

  mht_line_cmp #(.N(N_ENT), .LW(LINE_W)) u_am (
    .vld(vld), .lines(e_line), .probe(a_line), .hit(am_hit));
  mht_line_cmp #(.N(N_ENT), .LW(LINE_W)) u_rm (
    .vld(vld), .lines(e_line), .probe(r_line), .hit(rm_hit));
  mht_line_cmp #(.N(N_ENT), .LW(LINE_W)) u_qm (
    .vld(vld), .lines(e_line), .probe(q_line), .hit(qm_hit));

  // same set index and same way: the fill would land on another miss
  for (genvar g = 0; g < N_ENT; g++) begin : g_setway
    assign sw_hit[g] = vld[g] &&
                       (e_line[g][SET_W-1:0] == a_line[SET_W-1:0]) &&
                       (e_way[g] == alloc_way);
  end

  mht_first #(.N(N_ENT), .IW(IDX_W)) u_ap (.req(am_hit), .any(am_any), .idx(am_idx));
  mht_first #(.N(N_ENT), .IW(IDX_W)) u_fp (.req(~vld),   .any(fp_any), .idx(fp_idx));
  mht_first #(.N(N_ENT), .IW(IDX_W)) u_qp (.req(qm_hit), .any(qp_any), .idx(qp_idx));

  // allocation decision: line match first, then set/way clash, then space
  always_comb begin
    alloc_rsp = RSP_OK;
    alloc_idx = '0;
    alloc_ok  = 1'b0;
    if (am_any) begin
      if (merge_ok(mht_cmd_e'(e_cmd[am_idx]), mht_cmd_e'(alloc_cmd))) begin
        alloc_rsp = RSP_MERGE;
        alloc_idx = am_idx;
      end else begin
        alloc_rsp = RSP_CONFLICT;
      end
    end else if (|sw_hit) begin
      alloc_rsp = RSP_CONFLICT;
    end else if (!fp_any) begin
      alloc_rsp = RSP_FULL;
    end else begin
      alloc_idx = fp_idx;
      alloc_ok  = alloc_req;
    end
  end

  // release and insertion vectors
  always_comb begin
    clr = '0;
    if (free_req)   clr = clr | (N_ENT'(1) << free_idx);
    if (remove_req) clr = clr | rm_hit;
    drop   = clr & vld;
    dec    = CNT_W'($countones(drop));
    set_oh = alloc_ok ? (N_ENT'(1) << fp_idx) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld   <= '0;
      count <= '0;
    end else begin
      vld   <= (vld & ~clr) | set_oh;
      count <= next_count(count, alloc_ok, dec);
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_ok) begin
      e_line[fp_idx] <= a_line;
      e_cmd[fp_idx]  <= alloc_cmd;
      e_way[fp_idx]  <= alloc_way;
      e_l2[fp_idx]   <= alloc_l2hit;
    end
  end

  // classification
  always_comb begin
    query_kind = CLS_NONE;
    if (query_req && qp_any)
      query_kind = classify(e_l2[qp_idx], mht_cmd_e'(e_cmd[qp_idx]));
  end
  assign query_err = query_req && !qp_any;

  // barrier
  assign sync_stall = sync_req && (count != '0);
  assign sync_issue = sync_req && (count == '0);
  assign busy_count = count;

endmodule

// File: rtl/mht_table_chk.sv
module mht_table_chk
  import mht_pkg::*;
#(
  parameter int N_ENT = 8,
  parameter int IDX_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_req,
  input logic [1:0]       alloc_rsp,
  input logic [IDX_W-1:0] alloc_idx,
  input logic             free_req,
  input logic             remove_req,
  input logic             query_req,
  input logic [1:0]       query_kind,
  input logic             query_err,
  input logic             sync_req,
  input logic             sync_stall,
  input logic             sync_issue,
  input logic [CNT_W-1:0] busy_count,
  input logic [N_ENT-1:0] vld
);
  a_r9_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    busy_count == CNT_W'($countones(vld)));

  a_r3_ok_targets_free: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_rsp == RSP_OK) |-> !vld[alloc_idx]);

  a_r3_ok_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_rsp == RSP_OK) |=> vld[$past(alloc_idx)]);

  a_r4_merge_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_rsp == RSP_MERGE && !free_req && !remove_req)
      |=> busy_count == $past(busy_count));

  a_r6_full_all_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_req && alloc_rsp == RSP_FULL) |-> (&vld));

  a_r10_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |-> (sync_stall != sync_issue));

  a_r10_issue_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    sync_issue |-> (vld == '0));

  a_r12_err_kind: assert property (@(posedge clk) disable iff (!rst_n)
    query_err |-> (query_req && query_kind == CLS_NONE));
endmodule

bind mht_table mht_table_chk #(.N_ENT(N_ENT), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_rsp(alloc_rsp),
  .alloc_idx(alloc_idx), .free_req(free_req), .remove_req(remove_req),
  .query_req(query_req), .query_kind(query_kind), .query_err(query_err),
  .sync_req(sync_req), .sync_stall(sync_stall), .sync_issue(sync_issue),
  .busy_count(busy_count), .vld(vld));

// File: tb/mht_table_test.sv
module mht_table_test;
  localparam int NE = 8;
  localparam int IW = 3;
  localparam int CW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_req = 0, alloc_l2hit = 0, free_req = 0, remove_req = 0;
  logic        query_req = 0, sync_req = 0;
  logic [31:0] alloc_addr = '0, remove_addr = '0, query_addr = '0;
  logic [1:0]  alloc_cmd = '0;
  logic [1:0]  alloc_way = '0;
  logic [IW-1:0] free_idx = '0;
  logic [1:0]  alloc_rsp, query_kind;
  logic [IW-1:0] alloc_idx;
  logic        query_err, sync_stall, sync_issue;
  logic [CW-1:0] busy_count;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mht_table uut (
    .clk(clk), .rst_n(rst_n),
    .alloc_req(alloc_req), .alloc_addr(alloc_addr), .alloc_cmd(alloc_cmd),
    .alloc_way(alloc_way), .alloc_l2hit(alloc_l2hit),
    .alloc_rsp(alloc_rsp), .alloc_idx(alloc_idx),
    .free_req(free_req), .free_idx(free_idx),
    .remove_req(remove_req), .remove_addr(remove_addr),
    .query_req(query_req), .query_addr(query_addr),
    .query_kind(query_kind), .query_err(query_err),
    .sync_req(sync_req), .sync_stall(sync_stall), .sync_issue(sync_issue),
    .busy_count(busy_count));

  // ops: 0 alloc, 1 free, 2 remove, 3 query, 4 sync
  typedef struct packed {
    logic [2:0]  op;
    logic [31:0] addr;
    logic [1:0]  cmd;
    logic [1:0]  way;
    logic        l2;
    logic [2:0]  idx;   // free index, or expected alloc index
    logic [1:0]  ea;    // expected rsp / kind / stall
    logic [3:0]  ecnt;  // expected count after the edge
    logic [3:0]  req;   // requirement number for messages
  } vec_t;

  localparam vec_t VEC [0:17] = '{
    '{3'd0, 32'h1000_0040, 2'd0, 2'd0, 1'b0, 3'd0, 2'd0, 4'd1, 4'd3},  // R3 first slot
    '{3'd0, 32'h1000_005C, 2'd0, 2'd0, 1'b0, 3'd0, 2'd1, 4'd1, 4'd2},  // R2 offset ignored, merge
    '{3'd0, 32'h1000_0044, 2'd1, 2'd0, 1'b0, 3'd0, 2'd2, 4'd1, 4'd5},  // R5 shared held, excl wanted
    '{3'd0, 32'h2000_0040, 2'd1, 2'd0, 1'b0, 3'd0, 2'd2, 4'd1, 4'd5},  // R5 set/way clash
    '{3'd0, 32'h2000_0040, 2'd1, 2'd1, 1'b0, 3'd1, 2'd0, 4'd2, 4'd3},
    '{3'd0, 32'h2000_0060, 2'd0, 2'd0, 1'b0, 3'd2, 2'd0, 4'd3, 4'd3},
    '{3'd0, 32'h2000_0048, 2'd0, 2'd1, 1'b0, 3'd1, 2'd1, 4'd3, 4'd4},  // R4 excl held
    '{3'd3, 32'h1000_0050, 2'd0, 2'd0, 1'b0, 3'd0, 2'd1, 4'd3, 4'd11}, // R11 L2
    '{3'd0, 32'h3000_0080, 2'd2, 2'd2, 1'b0, 3'd3, 2'd0, 4'd4, 4'd3},
    '{3'd3, 32'h3000_0090, 2'd0, 2'd0, 1'b0, 3'd0, 2'd2, 4'd4, 4'd11}, // R11 upgrade
    '{3'd0, 32'h3000_00A0, 2'd1, 2'd2, 1'b1, 3'd4, 2'd0, 4'd5, 4'd3},
    '{3'd3, 32'h3000_00A4, 2'd0, 2'd0, 1'b0, 3'd0, 2'd0, 4'd5, 4'd11}, // R11 L1
    '{3'd3, 32'h4000_0000, 2'd0, 2'd0, 1'b0, 3'd0, 2'd3, 4'd5, 4'd12}, // R12
    '{3'd4, 32'h0000_0000, 2'd0, 2'd0, 1'b0, 3'd0, 2'd1, 4'd5, 4'd10}, // R10 stall
    '{3'd1, 32'h0000_0000, 2'd0, 2'd0, 1'b0, 3'd2, 2'd0, 4'd4, 4'd7},  // R7 free
    '{3'd0, 32'h5000_0000, 2'd0, 2'd0, 1'b0, 3'd2, 2'd0, 4'd5, 4'd3},  // R3 lowest free reused
    '{3'd2, 32'h1000_0040, 2'd0, 2'd0, 1'b0, 3'd0, 2'd0, 4'd4, 4'd8},  // R8 remove
    '{3'd3, 32'h1000_0040, 2'd0, 2'd0, 1'b0, 3'd0, 2'd3, 4'd4, 4'd8}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    alloc_req = 0; free_req = 0; remove_req = 0; query_req = 0; sync_req = 0;
    alloc_l2hit = 0;
  endtask

  task automatic count_after_edge(input string req, input int exp);
    @(posedge clk); #1;
    idle();
    check(req, "busy_count", 32'(busy_count), 32'(exp));
  endtask

  task automatic do_alloc(input logic [31:0] a, input logic [1:0] c,
                          input logic [1:0] w, input logic l2,
                          input int ersp, input int eidx, input int ecnt,
                          input string req);
    @(negedge clk);
    alloc_req = 1; alloc_addr = a; alloc_cmd = c; alloc_way = w; alloc_l2hit = l2;
    #1;
    check(req, "alloc_rsp", 32'(alloc_rsp), 32'(ersp));
    if (ersp <= 1) check(req, "alloc_idx", 32'(alloc_idx), 32'(eidx));
    count_after_edge(req, ecnt);
  endtask

  task automatic do_free(input int i, input int ecnt, input string req);
    @(negedge clk);
    free_req = 1; free_idx = IW'(i);
    count_after_edge(req, ecnt);
  endtask

  task automatic do_remove(input logic [31:0] a, input int ecnt, input string req);
    @(negedge clk);
    remove_req = 1; remove_addr = a;
    count_after_edge(req, ecnt);
  endtask

  task automatic do_query(input logic [31:0] a, input int ekind, input string req);
    @(negedge clk);
    query_req = 1; query_addr = a;
    #1;
    check(req, "query_kind", 32'(query_kind), 32'(ekind));
    check(req, "query_err", 32'(query_err), 32'(ekind == 3));
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_sync(input int estall, input string req);
    @(negedge clk);
    sync_req = 1;
    #1;
    check(req, "sync_stall", 32'(sync_stall), 32'(estall));
    check(req, "sync_issue", 32'(sync_issue), 32'(estall == 0));
    @(posedge clk); #1;
    idle();
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    check("R1", "busy_count", 32'(busy_count), 32'd0);
    do_sync(0, "R1");
    do_query(32'h1000_0040, 3, "R1");

    // vector table
    for (int v = 0; v < 18; v++) begin
      string r;
      r = $sformatf("R%0d", VEC[v].req);
      case (VEC[v].op)
        3'd0: do_alloc(VEC[v].addr, VEC[v].cmd, VEC[v].way, VEC[v].l2,
                       int'(VEC[v].ea), int'(VEC[v].idx), int'(VEC[v].ecnt), r);
        3'd1: do_free(int'(VEC[v].idx), int'(VEC[v].ecnt), r);
        3'd2: do_remove(VEC[v].addr, int'(VEC[v].ecnt), r);
        3'd3: do_query(VEC[v].addr, int'(VEC[v].ea), r);
        default: do_sync(int'(VEC[v].ea), r);
      endcase
    end

    // R6 fill remaining slots 0,5,6,7 then overflow
    do_alloc(32'h6000_0100, 2'd0, 2'd3, 1'b0, 0, 0, 5, "R3");
    do_alloc(32'h6000_0120, 2'd0, 2'd3, 1'b0, 0, 5, 6, "R3");
    do_alloc(32'h6000_0140, 2'd0, 2'd3, 1'b0, 0, 6, 7, "R3");
    do_alloc(32'h6000_0160, 2'd0, 2'd3, 1'b0, 0, 7, 8, "R3");
    do_alloc(32'h7000_0200, 2'd1, 2'd3, 1'b0, 3, 0, 8, "R6");
    do_query(32'h7000_0200, 3, "R6");

    // R9 allocate and free in one cycle
    do_free(5, 7, "R7");
    @(negedge clk);
    alloc_req = 1; alloc_addr = 32'h7000_0200; alloc_cmd = 2'd1; alloc_way = 2'd0;
    free_req = 1; free_idx = 3'd6;
    #1;
    check("R9", "alloc_rsp", 32'(alloc_rsp), 32'd0);
    check("R9", "alloc_idx", 32'(alloc_idx), 32'd5);
    count_after_edge("R9", 7);
    do_query(32'h6000_0140, 3, "R9");
    do_query(32'h7000_0200, 1, "R9");

    // R7 freeing an unoccupied slot changes nothing
    do_free(6, 7, "R7");
    // R8 remove present and absent lines
    do_remove(32'h6000_0110, 6, "R8");
    do_query(32'h6000_0100, 3, "R8");
    do_remove(32'h0ABC_0000, 6, "R8");
    do_sync(1, "R10");

    // drain by index, then the barrier goes through
    for (int i = 0; i < NE; i++) begin
      @(negedge clk);
      free_req = 1; free_idx = IW'(i);
      @(posedge clk); #1;
      idle();
    end
    check("R9", "busy_count drained", 32'(busy_count), 32'd0);
    do_sync(0, "R10");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule